// File: doc/BRIEF.md
# RTC Host Bus Bridge with Paged Extended RAM

This block sits between an 8-bit asynchronous host bus and two storage areas: a 64-byte clock register file and an extended byte RAM. The clock file is not mapped flat. The host first writes a location number into an index register, then reads or writes that location through a data port. Address bit 0 picks between the index and the data port. The extended RAM is reached through a page register and a 32-byte window. Address bit 5 high selects the page register. Address bit 5 low makes bits 4..0 choose a byte inside the current page. The first 14 locations of the clock file are the clock and control bytes, and the other 50 are general purpose. All 64 are kept here as plain storage, because timekeeping lives elsewhere.

The strobes, both selects, standby and the bus reset are asynchronous to the system clock. Each passes through a two-flop synchronizer. A write is committed on the rising edge of the write strobe, as seen in the clock domain, using the address, data and target held while the strobe was low. The read path is exposed as a data vector plus an output enable, and a pad ring turns these into a tri-state driver. The full 8K part uses 256 pages and is built by setting `RAM_PAGES` to 256. The default is a smaller array with the same 8-bit page register.

Top module: `rtc_bus_bridge`

## Requirements
- R1: With the RTC select low and A0=0, a write stores data bits 5..0 in the index register, and a read returns the index with bits 7..6 zero. A value of 0x47 reads back as 0x07.
- R2: With the RTC select low and A0=1, reads and writes act on the clock-file location named by the index. The index does not change after a data-port access.
- R3: The 64 clock-file locations are separate storage, so writing one location leaves the others unchanged.
- R4: With the XRAM select low and A5=1, the full 8-bit page register is written and read back.
- R5: With the XRAM select low and A5=0, A4..A0 address a byte in the current page. The same offset in different pages holds separate data.
- R6: The output enable is high only while RD is low, a select is low and standby is high. In all other cases it is low.
- R7: A write takes effect only after WR returns high. While WR is still low, a read of the same location returns the old value.
- R8: While standby is low, reads do not enable the output and writes are dropped. Stored data is kept.
- R9: While the bus reset is low, the index and data ports neither drive the bus nor accept writes. The extended RAM stays reachable.
- R10: When both selects are low, the access goes to the clock file only.
- R11: After the system reset, the output enable is low and both the index and the page register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset for the clock-domain logic |
| rtc_sel_n | input | 1 | Active-low clock-file select |
| xram_sel_n | input | 1 | Active-low extended-RAM select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; commits on its rising edge |
| addr | input | 6 | Host address A5..A0 |
| din | input | 8 | Host write data |
| stby_n | input | 1 | Active-low standby; blocks all accesses |
| bus_rst_n | input | 1 | Active-low bus reset; blocks clock-file access |
| dout | output | 8 | Read data, zero when not enabled |
| dout_oe | output | 1 | Output enable for the data bus driver |

## Verification
Read results depend on the two synchronizer stages. The output enable and the data are valid after the second rising clock edge following RD, a select or standby going low. The bench therefore samples on the third falling edge after it drives them. A write reaches storage on the third rising edge after WR goes high: two sync stages and one edge-detect stage. The bench holds address, data and select for four cycles past the rise and waits five cycles before any read that depends on the write. The read-during-write check is sampled one cycle before WR rises, so the old value is still due at that point.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_INDEX = 3'd1,
    TGT_RDATA = 3'd2,
    TGT_PAGE  = 3'd3,
    TGT_XBYTE = 3'd4
  } tgt_e;

  // Map the selects and address onto one storage target.
  // The clock file wins when both selects are active.
  function automatic tgt_e decode_tgt(input logic rtc_act,
                                      input logic xram_act,
                                      input logic bus_live,
                                      input logic rtc_open,
                                      input logic [5:0] a);
    tgt_e t;
    t = TGT_NONE;
    if (bus_live) begin
      if (rtc_act) begin
        if (rtc_open) t = a[0] ? TGT_RDATA : TGT_INDEX;
      end else if (xram_act) begin
        t = a[5] ? TGT_PAGE : TGT_XBYTE;
      end
    end
    return t;
  endfunction

  function automatic logic is_rtc_tgt(input tgt_e t);
    return (t == TGT_INDEX) || (t == TGT_RDATA);
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_idx,
  input  logic              wr_dat,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (wr_idx) idx <= wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_dat) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/xram_window.sv
module xram_window #(
  parameter int PAGE_W    = 8,
  parameter int OFFS_W    = 5,
  parameter int RAM_PAGES = 64,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_page,
  input  logic              wr_byte,
  input  logic [OFFS_W-1:0] rd_offs,
  input  logic [OFFS_W-1:0] wr_offs,
  input  logic [DATA_W-1:0] wdata,
  output logic [PAGE_W-1:0] page,
  output logic [DATA_W-1:0] rdata
);
  localparam int PSEL_W = (RAM_PAGES > 1) ? $clog2(RAM_PAGES) : 1;
  localparam int DEPTH  = RAM_PAGES << OFFS_W;
  localparam int AW     = PSEL_W + OFFS_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;

  // Page numbers above the array size alias onto lower pages.
  assign rd_ptr = {page[PSEL_W-1:0], rd_offs};
  assign wr_ptr = {page[PSEL_W-1:0], wr_offs};

  generate
    if (PSEL_W < PAGE_W) begin : g_alias
      logic unused_page_hi;
      assign unused_page_hi = ^page[PAGE_W-1:PSEL_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else if (wr_page) page <= wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_byte) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rtc_bus_bridge.sv
module rtc_bus_bridge
  import rtc_bus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 6,
  parameter int PAGE_W    = 8,
  parameter int OFFS_W    = 5,
  parameter int RAM_PAGES = 64
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              rtc_sel_n,
  input  logic              xram_sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              stby_n,
  input  logic              bus_rst_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int NSYNC = 6;
  // Bit order: rtc_sel_n, xram_sel_n, rd_n, wr_n, stby_n, bus_rst_n.
  localparam logic [NSYNC-1:0] SYNC_RST = 6'b111100;

  logic [NSYNC-1:0] raw_ctl, sync_ctl;
  assign raw_ctl = {rtc_sel_n, xram_sel_n, rd_n, wr_n, stby_n, bus_rst_n};

  bus_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(sys_rst_n),
    .d    (raw_ctl),
    .q    (sync_ctl)
  );

  // Named clock-domain events, also observed by the checker.
  logic rtc_act, xram_act, rd_act, wr_s, stby_ok, rtc_open;
  assign rtc_act  = ~sync_ctl[5];
  assign xram_act = ~sync_ctl[4];
  assign rd_act   = ~sync_ctl[3];
  assign wr_s     =  sync_ctl[2];
  assign stby_ok  =  sync_ctl[1];
  assign rtc_open =  sync_ctl[0];

  // Write capture: hold the target and payload while the strobe is low.
  logic              wr_prev;
  tgt_e              hold_tgt;
  logic [OFFS_W-1:0] hold_offs;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      wr_prev   <= 1'b1;
      hold_tgt  <= TGT_NONE;
      hold_offs <= '0;
      hold_data <= '0;
    end else begin
      wr_prev <= wr_s;
      if (!wr_s) begin
        hold_tgt  <= decode_tgt(rtc_act, xram_act, stby_ok, rtc_open, addr);
        hold_offs <= addr[OFFS_W-1:0];
        hold_data <= din;
      end
    end
  end

  logic wr_rise, wr_commit;
  tgt_e commit_tgt;
  assign wr_rise = wr_s & ~wr_prev;

  always_comb begin
    commit_tgt = TGT_NONE;
    if (wr_rise && stby_ok && (rtc_open || !is_rtc_tgt(hold_tgt)))
      commit_tgt = hold_tgt;
  end
  assign wr_commit = (commit_tgt != TGT_NONE);

  // Storage
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rtc_rdata, xram_rdata;
  logic [PAGE_W-1:0] page;

  rtc_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rtc (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .wr_idx(commit_tgt == TGT_INDEX),
    .wr_dat(commit_tgt == TGT_RDATA),
    .wdata (hold_data),
    .idx   (idx),
    .rdata (rtc_rdata)
  );

  xram_window #(
    .PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .RAM_PAGES(RAM_PAGES), .DATA_W(DATA_W)
  ) u_xram (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .wr_page(commit_tgt == TGT_PAGE),
    .wr_byte(commit_tgt == TGT_XBYTE),
    .rd_offs(addr[OFFS_W-1:0]),
    .wr_offs(hold_offs),
    .wdata  (hold_data),
    .page   (page),
    .rdata  (xram_rdata)
  );

  // Read path
  tgt_e rd_tgt;
  assign rd_tgt  = decode_tgt(rtc_act, xram_act, stby_ok, rtc_open, addr);
  assign dout_oe = rd_act && (rd_tgt != TGT_NONE);

  always_comb begin
    dout = '0;
    if (dout_oe) begin
      case (rd_tgt)
        TGT_INDEX: dout = {{(DATA_W-IDX_W){1'b0}}, idx};
        TGT_RDATA: dout = rtc_rdata;
        TGT_PAGE:  dout = {{(DATA_W-PAGE_W){1'b0}}, page};
        TGT_XBYTE: dout = xram_rdata;
        default:   dout = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_bus_bridge_chk.sv
module rtc_bus_bridge_chk
  import rtc_bus_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dout_oe,
  input logic              rd_act,
  input logic              rtc_act,
  input logic              xram_act,
  input logic              stby_ok,
  input logic              rtc_open,
  input logic              wr_commit,
  input tgt_e              commit_tgt,
  input logic [IDX_W-1:0]  idx,
  input logic [PAGE_W-1:0] page
);
  a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (rd_act && stby_ok && (rtc_act || xram_act)));

  a_r8_no_commit_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> stby_ok);

  a_r9_rtc_commit_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_tgt == TGT_INDEX) || (commit_tgt == TGT_RDATA)) |-> rtc_open);

  a_r9_blocked_read_is_xram: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && !rtc_open) |-> (xram_act && !rtc_act));

  a_r1_index_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit_tgt != TGT_INDEX) |-> $stable(idx));

  a_r4_page_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit_tgt != TGT_PAGE) |-> $stable(page));

  a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

bind rtc_bus_bridge rtc_bus_bridge_chk #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (sys_rst_n),
  .dout_oe   (dout_oe),
  .rd_act    (rd_act),
  .rtc_act   (rtc_act),
  .xram_act  (xram_act),
  .stby_ok   (stby_ok),
  .rtc_open  (rtc_open),
  .wr_commit (wr_commit),
  .commit_tgt(commit_tgt),
  .idx       (idx),
  .page      (page)
);

// File: tb/sim_rtc_bus_bridge.sv
`timescale 1ns/1ps
module sim_rtc_bus_bridge;
  logic       clk = 1'b0;
  logic       sys_rst_n = 1'b0;
  logic       rtc_sel_n = 1'b1, xram_sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic       stby_n = 1'b1, bus_rst_n = 1'b1;
  logic [7:0] dout;
  logic       dout_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rtc_bus_bridge u0 (
    .clk(clk), .sys_rst_n(sys_rst_n), .rtc_sel_n(rtc_sel_n), .xram_sel_n(xram_sel_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din), .stby_n(stby_n),
    .bus_rst_n(bus_rst_n), .dout(dout), .dout_oe(dout_oe)
  );

  // Vector: [23] write, [22] clock file (else xram), [21:16] addr, [15:8] data, [7:0] expected
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b1, 6'h00, 8'h05, 8'h00},
    {1'b1, 1'b1, 6'h01, 8'hA5, 8'h00},
    {1'b0, 1'b1, 6'h00, 8'h00, 8'h05},
    {1'b0, 1'b1, 6'h01, 8'h00, 8'hA5},
    {1'b0, 1'b1, 6'h01, 8'h00, 8'hA5},
    {1'b1, 1'b1, 6'h00, 8'h3F, 8'h00},
    {1'b1, 1'b1, 6'h01, 8'h3C, 8'h00},
    {1'b0, 1'b1, 6'h01, 8'h00, 8'h3C},
    {1'b0, 1'b1, 6'h00, 8'h00, 8'h3F},
    {1'b1, 1'b1, 6'h00, 8'h05, 8'h00},
    {1'b0, 1'b1, 6'h01, 8'h00, 8'hA5},
    {1'b1, 1'b0, 6'h20, 8'h03, 8'h00},
    {1'b1, 1'b0, 6'h07, 8'h77, 8'h00},
    {1'b0, 1'b0, 6'h20, 8'h00, 8'h03},
    {1'b0, 1'b0, 6'h07, 8'h00, 8'h77},
    {1'b1, 1'b0, 6'h20, 8'h04, 8'h00},
    {1'b1, 1'b0, 6'h07, 8'h11, 8'h00},
    {1'b0, 1'b0, 6'h07, 8'h00, 8'h11},
    {1'b1, 1'b0, 6'h20, 8'h03, 8'h00},
    {1'b0, 1'b0, 6'h07, 8'h00, 8'h77},
    {1'b0, 1'b0, 6'h20, 8'h00, 8'h03}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic to_rtc, input logic to_xram,
                           input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    rtc_sel_n = ~to_rtc; xram_sel_n = ~to_xram; addr = a; din = d; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    rtc_sel_n = 1'b1; xram_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic to_rtc, input logic to_xram, input logic [5:0] a,
                          output logic [7:0] d, output logic oe);
    @(negedge clk);
    rtc_sel_n = ~to_rtc; xram_sel_n = ~to_xram; addr = a; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout; oe = dout_oe;
    rd_n = 1'b1; rtc_sel_n = 1'b1; xram_sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic       oe;

    // R11: reset state
    repeat (5) @(negedge clk);
    check("R11 oe in reset", {7'd0, dout_oe}, 8'h00);
    sys_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 1'b0, 6'h00, rd, oe);
    check("R11 index after reset", rd, 8'h00);
    bus_read(1'b0, 1'b1, 6'h20, rd, oe);
    check("R11 page after reset", rd, 8'h00);

    // Vector table: R1, R2, R4, R5
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string tag;
      v = VEC[i];
      if (v[22]) tag = v[16] ? "R2 data port" : "R1 index";
      else       tag = v[21] ? "R4 page" : "R5 page byte";
      if (v[23]) bus_write(v[22], ~v[22], v[21:16], v[15:8]);
      else begin
        bus_read(v[22], ~v[22], v[21:16], rd, oe);
        check(tag, rd, v[7:0]);
        check({tag, " oe"}, {7'd0, oe}, 8'h01);
      end
    end

    // R1: only six index bits kept; R3: locations are separate
    bus_write(1'b1, 1'b0, 6'h00, 8'h47);
    bus_read(1'b1, 1'b0, 6'h00, rd, oe);
    check("R1 index wrap", rd, 8'h07);
    bus_write(1'b1, 1'b0, 6'h01, 8'h99);
    bus_write(1'b1, 1'b0, 6'h00, 8'h05);
    bus_read(1'b1, 1'b0, 6'h01, rd, oe);
    check("R3 loc5 kept", rd, 8'hA5);
    bus_write(1'b1, 1'b0, 6'h00, 8'h3F);
    bus_read(1'b1, 1'b0, 6'h01, rd, oe);
    check("R3 loc63 kept", rd, 8'h3C);

    // R10: both selects -> clock file wins
    bus_write(1'b0, 1'b1, 6'h00, 8'h55);
    bus_write(1'b1, 1'b1, 6'h00, 8'h09);
    bus_read(1'b0, 1'b1, 6'h00, rd, oe);
    check("R10 xram byte untouched", rd, 8'h55);
    bus_read(1'b1, 1'b0, 6'h00, rd, oe);
    check("R10 index written", rd, 8'h09);

    // R7: read during a write sees the old value until WR rises
    bus_write(1'b1, 1'b0, 6'h00, 8'h05);
    @(negedge clk);
    rtc_sel_n = 1'b0; addr = 6'h01; din = 8'h5A; wr_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 old value while WR low", dout, 8'hA5);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 new value after WR rise", dout, 8'h5A);
    rd_n = 1'b1; rtc_sel_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: standby blocks reads and writes, keeps data
    stby_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 1'b0, 6'h01, rd, oe);
    check("R8 oe in standby", {7'd0, oe}, 8'h00);
    bus_write(1'b1, 1'b0, 6'h01, 8'hEE);
    stby_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 1'b0, 6'h01, rd, oe);
    check("R8 data kept", rd, 8'h5A);

    // R9: bus reset blocks the clock file only
    bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 1'b0, 6'h00, rd, oe);
    check("R9 rtc oe blocked", {7'd0, oe}, 8'h00);
    bus_write(1'b1, 1'b0, 6'h00, 8'h22);
    bus_read(1'b0, 1'b1, 6'h07, rd, oe);
    check("R9 xram reachable", rd, 8'h77);
    check("R9 xram oe", {7'd0, oe}, 8'h01);
    bus_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(1'b1, 1'b0, 6'h00, rd, oe);
    check("R9 index unchanged", rd, 8'h05);

    // R6: enable needs both RD and a select
    @(negedge clk);
    rtc_sel_n = 1'b0; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 select without RD", {7'd0, dout_oe}, 8'h00);
    rtc_sel_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 RD without select", {7'd0, dout_oe}, 8'h00);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule